// File: doc/BRIEF.md
# Priority Pin Crossbar Decoder

This block places a set of enabled digital peripheral signals onto a bank of general-purpose port pins. A configuration register holds one enable bit per peripheral resource, an SPI wire-mode bit, a per-pin skip mask and a GPIO latch (output value and output enable per pin). From that register a combinational allocator works out which signal owns each pin. The UART pair is placed first, at two fixed pins. Every other resource is then placed, in a fixed priority order, on the lowest pins that are still free.

Each pin reports a 4-bit select code naming its owner, or 0 for plain GPIO. The block then routes the pins. An owned pin drives the output value and output enable of its peripheral signal. A GPIO or skipped pin drives the GPIO latch. Each peripheral input reads its pin, or a constant 1 when its signal owns no pin. The peripherals themselves are stand-in signal ports. When the enabled resources do not all fit, an overflow flag is raised.

Top module: `pin_crossbar`

## Requirements
- R1: After reset every pin has select code 0 (GPIO), `pin_oe` is all zero, `overflow` is 0 and every bit of `sig_in` is 1.
- R2: The configuration inputs are captured only in a cycle with `cfg_we` high. `pin_sel` shows the new assignment after that clock edge and not before it. With `cfg_we` low, changes on the configuration inputs have no effect.
- R3: When the UART is enabled (`cfg_res_en` bit 0), pin 4 carries code 1 (TX) and pin 5 carries code 2 (RX). This holds even when the skip bits of those pins are set.
- R4: When the UART is disabled, pins 4 and 5 are free for lower-priority resources.
- R5: After the UART, resources are placed in this order: SPI (bit 1), SMBus (bit 2), comparator 0 (bit 3), comparator 1 (bit 4), timer channels 0, 1 and 2 (bits 5, 6, 7). Each resource takes the lowest free pins, in its own signal order. The codes are: 3 SCK, 4 MISO, 5 MOSI, 6 NSS, 7 SDA, 8 SCL, 9 CP0, 10 CP1, 11 T0, 12 T1, 13 T2.
- R6: A pin whose `cfg_skip` bit is set is treated as taken. It keeps code 0, except in the UART case of R3.
- R7: With `cfg_spi4` = 1 the SPI takes four pins (SCK, MISO, MOSI, NSS). With `cfg_spi4` = 0 it takes three pins, and NSS is not placed.
- R8: A resource is placed whole or not at all. If an enabled resource needs more pins than remain free, it gets no pins and `overflow` is 1. Every lower-priority resource after it also gets no pins.
- R9: An owned pin drives `sig_out` and `sig_oe` of its owning signal onto `pin_out` and `pin_oe`. A GPIO or skipped pin drives the GPIO latch bits written through `cfg_gpio_out` and `cfg_gpio_oe`.
- R10: Each `sig_in` bit carries `pin_in` of the pin its signal owns. It reads 1 when the signal owns no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_res_en | input | 8 | Resource enable bits (see R5) |
| cfg_spi4 | input | 1 | 1 = SPI four-wire, 0 = three-wire |
| cfg_skip | input | 8 | Per-pin skip mask |
| cfg_gpio_out | input | 8 | GPIO latch output values |
| cfg_gpio_oe | input | 8 | GPIO latch output enables |
| sig_out | input | 13 | Peripheral output values, bit = code - 1 |
| sig_oe | input | 13 | Peripheral output enables, bit = code - 1 |
| sig_in | output | 13 | Peripheral inputs, bit = code - 1 |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| pin_sel | output | 32 | Select code of pin p in bits [4p+3:4p] |
| overflow | output | 1 | Enabled resources did not all fit |

## Verification
The allocator is tried with several configurations. The UART alone shows the fixed pair. UART plus four-wire SPI shows placement around the pair, and UART plus three-wire SPI plus SMBus shows pins filled on both sides of it. The SPI alone with low pins skipped shows that pins 4 and 5 are free. Only the single-pin resources enabled exercises the priority order. The UART with its own pins skipped shows that the pair overrides the skip mask. Three crowded configurations tell an exact fit apart from overflow of a later resource, and from refusal of a partial SPI placement that also blocks the SMBus. Routing patterns with mixed owned, GPIO and skipped pins, plus an unrouted NSS, separate the pin-to-signal and signal-to-pin paths from the latch and idle-level paths.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    localparam int NSIG = 13;
    localparam int NRES = 8;
    localparam int SELW = 4;

    function automatic logic [SELW-1:0] res_base(input int r);
        case (r)
            0: return SELW'(1);
            1: return SELW'(3);
            2: return SELW'(7);
            default: return SELW'(r + 6);
        endcase
    endfunction

    function automatic int res_need(input int r, input logic spi4);
        case (r)
            0: return 2;
            1: return spi4 ? 4 : 3;
            2: return 2;
            default: return 1;
        endcase
    endfunction
endpackage

// File: rtl/xbar_cfg_regs.sv
module xbar_cfg_regs #(
    parameter int NPIN = 8,
    parameter int NRES = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [NRES-1:0] en_d,
    input  logic            spi4_d,
    input  logic [NPIN-1:0] skip_d,
    input  logic [NPIN-1:0] gout_d,
    input  logic [NPIN-1:0] goe_d,
    output logic [NRES-1:0] en_q,
    output logic            spi4_q,
    output logic [NPIN-1:0] skip_q,
    output logic [NPIN-1:0] gout_q,
    output logic [NPIN-1:0] goe_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            spi4_q <= 1'b0;
            skip_q <= '0;
            gout_q <= '0;
            goe_q  <= '0;
        end else if (we) begin
            en_q   <= en_d;
            spi4_q <= spi4_d;
            skip_q <= skip_d;
            gout_q <= gout_d;
            goe_q  <= goe_d;
        end
    end
endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc
    import xbar_pkg::*;
#(
    parameter int NPIN   = 8,
    parameter int TX_PIN = 4,
    parameter int RX_PIN = 5
) (
    input  logic [NRES-1:0]           en,
    input  logic                      spi4,
    input  logic [NPIN-1:0]           skip,
    output logic [NPIN-1:0][SELW-1:0] sel,
    output logic                      ovf
);
    logic [NPIN-1:0] taken;
    logic            stop;
    logic            found;
    int              need;
    int              free_n;

    always_comb begin
        taken  = skip;
        sel    = '0;
        ovf    = 1'b0;
        stop   = 1'b0;
        found  = 1'b0;
        need   = 0;
        free_n = 0;
        if (en[0]) begin
            taken[TX_PIN] = 1'b1;
            taken[RX_PIN] = 1'b1;
            sel[TX_PIN]   = res_base(0);
            sel[RX_PIN]   = res_base(0) + SELW'(1);
        end
        for (int r = 1; r < NRES; r++) begin
            need = res_need(r, spi4);
            if (en[r] && !stop) begin
                free_n = $countones(~taken);
                if (free_n < need) begin
                    ovf  = 1'b1;
                    stop = 1'b1;
                end else begin
                    for (int k = 0; k < 4; k++) begin
                        if (k < need) begin
                            found = 1'b0;
                            for (int p = 0; p < NPIN; p++) begin
                                if (!found && !taken[p]) begin
                                    found    = 1'b1;
                                    taken[p] = 1'b1;
                                    sel[p]   = res_base(r) + SELW'(k);
                                end
                            end
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/xbar_pin_mux.sv
module xbar_pin_mux
    import xbar_pkg::*;
#(
    parameter int NPIN = 8
) (
    input  logic [NPIN-1:0][SELW-1:0] sel,
    input  logic [NPIN-1:0]           gout,
    input  logic [NPIN-1:0]           goe,
    input  logic [NSIG-1:0]           sig_out,
    input  logic [NSIG-1:0]           sig_oe,
    output logic [NSIG-1:0]           sig_in,
    input  logic [NPIN-1:0]           pin_in,
    output logic [NPIN-1:0]           pin_out,
    output logic [NPIN-1:0]           pin_oe
);
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        always_comb begin
            pin_out[p] = gout[p];
            pin_oe[p]  = goe[p];
            for (int s = 0; s < NSIG; s++) begin
                if (sel[p] == SELW'(s + 1)) begin
                    pin_out[p] = sig_out[s];
                    pin_oe[p]  = sig_oe[s];
                end
            end
        end
    end

    for (genvar s = 0; s < NSIG; s++) begin : g_sig
        always_comb begin
            sig_in[s] = 1'b1;
            for (int p = 0; p < NPIN; p++) begin
                if (sel[p] == SELW'(s + 1)) sig_in[s] = pin_in[p];
            end
        end
    end
endmodule

// File: rtl/pin_crossbar.sv
module pin_crossbar
    import xbar_pkg::*;
#(
    parameter int NPIN   = 8,
    parameter int TX_PIN = 4,
    parameter int RX_PIN = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [NRES-1:0]      cfg_res_en,
    input  logic                 cfg_spi4,
    input  logic [NPIN-1:0]      cfg_skip,
    input  logic [NPIN-1:0]      cfg_gpio_out,
    input  logic [NPIN-1:0]      cfg_gpio_oe,
    input  logic [NSIG-1:0]      sig_out,
    input  logic [NSIG-1:0]      sig_oe,
    output logic [NSIG-1:0]      sig_in,
    input  logic [NPIN-1:0]      pin_in,
    output logic [NPIN-1:0]      pin_out,
    output logic [NPIN-1:0]      pin_oe,
    output logic [NPIN*SELW-1:0] pin_sel,
    output logic                 overflow
);
    logic [NRES-1:0]           en_q;
    logic                      spi4_q;
    logic [NPIN-1:0]           skip_q;
    logic [NPIN-1:0]           gout_q;
    logic [NPIN-1:0]           goe_q;
    logic [NPIN-1:0][SELW-1:0] sel;

    xbar_cfg_regs #(.NPIN(NPIN), .NRES(NRES)) regs_i (
        .clk(clk), .rst_n(rst_n), .we(cfg_we),
        .en_d(cfg_res_en), .spi4_d(cfg_spi4), .skip_d(cfg_skip),
        .gout_d(cfg_gpio_out), .goe_d(cfg_gpio_oe),
        .en_q(en_q), .spi4_q(spi4_q), .skip_q(skip_q),
        .gout_q(gout_q), .goe_q(goe_q)
    );

    xbar_alloc #(.NPIN(NPIN), .TX_PIN(TX_PIN), .RX_PIN(RX_PIN)) alloc_i (
        .en(en_q), .spi4(spi4_q), .skip(skip_q), .sel(sel), .ovf(overflow)
    );

    xbar_pin_mux #(.NPIN(NPIN)) mux_i (
        .sel(sel), .gout(gout_q), .goe(goe_q),
        .sig_out(sig_out), .sig_oe(sig_oe), .sig_in(sig_in),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    assign pin_sel = sel;
endmodule

// File: rtl/xbar_checker.sv
module xbar_checker
    import xbar_pkg::*;
#(
    parameter int NPIN   = 8,
    parameter int TX_PIN = 4,
    parameter int RX_PIN = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_we,
    input logic [NRES-1:0]      en_q,
    input logic [NPIN-1:0]      skip_q,
    input logic [NPIN*SELW-1:0] pin_sel,
    input logic [NSIG-1:0]      sig_in
);
    logic [NSIG-1:0][NPIN-1:0] owns;
    logic [NPIN-1:0]           spi_pin;

    for (genvar s = 0; s < NSIG; s++) begin : g_own
        for (genvar p = 0; p < NPIN; p++) begin : g_p
            assign owns[s][p] = (pin_sel[p*SELW +: SELW] == SELW'(s + 1));
        end
        AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(owns[s]));                                   // R5
        AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (owns[s] == '0) |-> sig_in[s]);                       // R10
    end

    for (genvar p = 0; p < NPIN; p++) begin : g_skip
        assign spi_pin[p] = owns[2][p] | owns[3][p] | owns[4][p] | owns[5][p];
        if (p == TX_PIN || p == RX_PIN) begin : g_u
            AST_SKIP_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
                (skip_q[p] && !en_q[0]) |-> (pin_sel[p*SELW +: SELW] == '0)); // R6
        end else begin : g_n
            AST_SKIP_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
                skip_q[p] |-> (pin_sel[p*SELW +: SELW] == '0));   // R6
        end
    end

    AST_UART_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        en_q[0] |-> (pin_sel[TX_PIN*SELW +: SELW] == 4'd1 &&
                     pin_sel[RX_PIN*SELW +: SELW] == 4'd2));      // R3
    AST_NO_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(spi_pin) == 0 || $countones(spi_pin) >= 3));  // R8
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_we) |-> $stable(pin_sel));                     // R2
endmodule

bind pin_crossbar xbar_checker #(.NPIN(NPIN), .TX_PIN(TX_PIN), .RX_PIN(RX_PIN)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .en_q(en_q),
    .skip_q(skip_q), .pin_sel(pin_sel), .sig_in(sig_in)
);

// File: tb/pin_crossbar_tb_top.sv
module pin_crossbar_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_res_en = '0;
    logic        cfg_spi4 = 1'b0;
    logic [7:0]  cfg_skip = '0;
    logic [7:0]  cfg_gpio_out = '0;
    logic [7:0]  cfg_gpio_oe = '0;
    logic [12:0] sig_out = '0;
    logic [12:0] sig_oe = '0;
    logic [12:0] sig_in;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;
    logic [31:0] pin_sel;
    logic        overflow;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pin_crossbar dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_res_en(cfg_res_en),
        .cfg_spi4(cfg_spi4), .cfg_skip(cfg_skip), .cfg_gpio_out(cfg_gpio_out),
        .cfg_gpio_oe(cfg_gpio_oe), .sig_out(sig_out), .sig_oe(sig_oe),
        .sig_in(sig_in), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_sel(pin_sel), .overflow(overflow)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] en, input logic spi4, input logic [7:0] skip,
                             input logic [7:0] gout, input logic [7:0] goe);
        @(negedge clk);
        cfg_res_en = en; cfg_spi4 = spi4; cfg_skip = skip;
        cfg_gpio_out = gout; cfg_gpio_oe = goe; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic place(input string req, input logic [7:0] en, input logic spi4,
                         input logic [7:0] skip, input logic [31:0] exp_sel, input logic exp_ovf);
        write_cfg(en, spi4, skip, 8'h00, 8'h00);
        check(req, pin_sel, exp_sel);
        check(req, {31'd0, overflow}, {31'd0, exp_ovf});
    endtask

    task automatic t_reset;
        check("R1 sel", pin_sel, 32'h0);
        check("R1 oe", {24'd0, pin_oe}, 32'h0);
        check("R1 ovf", {31'd0, overflow}, 32'h0);
        check("R1 sig_in", {19'd0, sig_in}, 32'h1FFF);
    endtask

    task automatic t_latency;
        @(negedge clk);
        cfg_res_en = 8'h01; cfg_spi4 = 1'b0; cfg_skip = 8'h00; cfg_we = 1'b1;
        #2 check("R2 before edge", pin_sel, 32'h0);
        @(negedge clk);
        cfg_we = 1'b0;
        check("R2 after edge", pin_sel, 32'h0021_0000);
        cfg_res_en = 8'hF8;
        @(negedge clk);
        @(negedge clk);
        check("R2 no write", pin_sel, 32'h0021_0000);
    endtask

    task automatic t_routing;
        write_cfg(8'h03, 1'b1, 8'h00, 8'hFF, 8'hC0);
        sig_out = 13'h0005;
        sig_oe  = 13'h1FFD;
        pin_in  = 8'hA5;
        #1;
        check("R9 pin_out", {24'd0, pin_out}, 32'hD1);
        check("R9 pin_oe", {24'd0, pin_oe}, 32'hDF);
        check("R10 sig_in", {19'd0, sig_in}, 32'h1FD6);
        write_cfg(8'h03, 1'b0, 8'h00, 8'hFF, 8'hC0);
        #1 check("R10 nss idle", {31'd0, sig_in[5]}, 32'h1);
        write_cfg(8'h02, 1'b1, 8'h03, 8'h03, 8'h03);
        sig_out = 13'h0000;
        #1;
        check("R9 skipped pins latch", {30'd0, pin_out[1:0]}, 32'h3);
        check("R9 skipped pins oe", {30'd0, pin_oe[1:0]}, 32'h3);
    endtask

    initial begin
        #20000000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_latency();
        place("R3 uart only", 8'h01, 1'b0, 8'h00, 32'h0021_0000, 1'b0);
        place("R7 spi4 uart", 8'h03, 1'b1, 8'h00, 32'h0021_6543, 1'b0);
        place("R7 spi3 smb", 8'h07, 1'b0, 8'h00, 32'h0821_7543, 1'b0);
        place("R4 uart off skip", 8'h02, 1'b1, 8'h03, 32'h0065_4300, 1'b0);
        place("R8 late overflow", 8'h0F, 1'b1, 8'h00, 32'h8721_6543, 1'b1);
        place("R6 skip fit", 8'h03, 1'b1, 8'h0C, 32'h6521_0043, 1'b0);
        place("R8 no partial", 8'h07, 1'b1, 8'h8C, 32'h0021_0000, 1'b1);
        place("R5 singles order", 8'hF8, 1'b0, 8'h00, 32'h000D_CBA9, 1'b0);
        place("R3 uart over skip", 8'h09, 1'b0, 8'h30, 32'h0021_0009, 1'b0);
        t_routing();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule